// File: doc/BRIEF.md
# Halt Mode Wakeup Sequencer

This block decides when a small microcontroller core stops and when it runs again. Software sets a halt flag through a register write. The block then closes the core clock gate, turns off the oscillator, raises the watchdog-inhibit line and parks the clock-input pad. The pad is driven high for a resistor/capacitor oscillator and left floating for a crystal or external oscillator.

Two wake sources end the halt, and reset also ends it. The first source is a multi-input wakeup event. The second is a rising edge on the clock-output pin, which counts only when the RC oscillator is selected. On wakeup the oscillator is turned on first. A start-up timer then runs START_COUNT ticks of a prescaled clock, with OSC_DIV oscillator cycles per tick. Only after that does the core clock come back. For a crystal this delay is always applied. For RC it is applied only when the delay-enable bit is set; otherwise the clocks are released at once. A configuration input can block halt entirely.

Top module: `halt_wake_seq`

## Requirements
- R1: While reset is asserted and just after it is released, the outputs are: core_clk_en_o=1, osc_en_o=1, halt_flag_o=0, wdt_inhibit_o=0, cki_force_hi_o=0 and cki_hiz_o=0.
- R2: A halt write with data 1 while running and halt_disable_i=0 has an effect at the next clock edge: halt_flag_o=1, core_clk_en_o=0 and osc_en_o=0.
- R3: With halt_disable_i=1, a halt write with data 1 has no effect. halt_flag_o stays 0 and core_clk_en_o stays 1.
- R4: While halted, a high level on wake_mi_i ends the halt. osc_en_o is 1 after the third clock edge following the change: two edges for synchronizing and one for the state update.
- R5: A low-to-high edge on cko_pin_i ends the halt with the same three-edge latency, but only when osc_is_rc_i=1. When osc_is_rc_i=0 the edge is ignored and the block stays halted.
- R6: When the start-up delay applies, core_clk_en_o stays 0 and osc_en_o stays 1 for exactly START_COUNT*OSC_DIV clock edges after the halt ends. At the next edge core_clk_en_o becomes 1 and halt_flag_o becomes 0.
- R7: When osc_is_rc_i=1, the delay applies only if the delay-enable bit is 1. If the bit is 0, core_clk_en_o is 1 three edges after the wake input changes. Reset clears the delay-enable bit.
- R8: wdt_inhibit_o is 1 whenever halt_flag_o is 1, which covers both the halted state and the start-up delay. It is 0 while running.
- R9: While halted, cki_force_hi_o=1 and cki_hiz_o=0 when osc_is_rc_i=1, and cki_hiz_o=1 and cki_force_hi_o=0 when osc_is_rc_i=0. Both are 0 outside the halted state.
- R10: Asserting rst_ni low aborts a halt or a start-up count immediately and without a clock. The block returns to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_wr_i | input | 1 | Write strobe for the halt flag |
| halt_wdata_i | input | 1 | Data written to the halt flag |
| halt_disable_i | input | 1 | Option: 1 blocks halt entry |
| osc_is_rc_i | input | 1 | 1 = RC oscillator, 0 = crystal/external |
| dly_wr_i | input | 1 | Write strobe for the delay-enable bit |
| dly_wdata_i | input | 1 | Data written to the delay-enable bit |
| wake_mi_i | input | 1 | Multi-input wakeup event (level) |
| cko_pin_i | input | 1 | Clock-output pin sense |
| halt_flag_o | output | 1 | Halt flag readback |
| core_clk_en_o | output | 1 | Core and timer clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| cki_force_hi_o | output | 1 | Force clock-input pad high |
| cki_hiz_o | output | 1 | Float clock-input pad |
| wdt_inhibit_o | output | 1 | Watchdog detector inhibit |

## Verification
The assertions assume three things about the inputs. osc_is_rc_i and halt_disable_i do not change during a halt-to-run cycle. The wake inputs are low when halt is entered. Each clock-output edge is preceded by at least two low cycles. The stimulus follows these rules. It changes the configuration only while running, holds each wake input for exactly three edges, and waits several cycles after every release before the next halt write. The random choice of oscillator type, delay bit and wake source never pairs a crystal with clock-output wakeup, except in the one directed case where the bench checks that the edge is ignored.

// File: rtl/hws_pkg.sv
package hws_pkg;
   typedef enum logic [1:0] {
      HS_RUN   = 2'd0,
      HS_HALT  = 2'd1,
      HS_START = 2'd2
   } hs_state_e;
endpackage

// File: rtl/hws_sync.sv
module hws_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hws_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hws_startup_timer.sv
module hws_startup_timer #(
   parameter int DIV   = 10,
   parameter int COUNT = 256
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   output logic done_o
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int CW = $clog2(COUNT + 1);
   localparam logic [CW-1:0] CMAX = CW'(COUNT);
   localparam logic [CW-1:0] CONE = CW'(1);

   generate
      if (COUNT < 2) begin : g_bad_count
         $error("hws_startup_timer: COUNT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          tick;
   logic          active;

   assign active = (cnt_q != '0);

   generate
      if (DIV > 1) begin : g_prescale
         localparam logic [PW-1:0] PMAX = PW'(DIV - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      pre_q <= '0;
            else if (load_i)  pre_q <= '0;
            else if (active)  pre_q <= (pre_q == PMAX) ? '0 : pre_q + PW'(1);
         end
         assign tick = (pre_q == PMAX);
      end else begin : g_direct
         assign tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (load_i)          cnt_q <= CMAX;
      else if (active && tick)  cnt_q <= cnt_q - CONE;
   end

   assign done_o = active && tick && (cnt_q == CONE);

   // R6: each tick removes exactly one count
   p_count_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && tick && cnt_q > CONE) |=> (cnt_q == $past(cnt_q) - CONE));
   // R6: completion leaves the timer idle
   p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq #(
   parameter int OSC_DIV     = 10,
   parameter int START_COUNT = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic halt_wr_i,
   input  logic halt_wdata_i,
   input  logic halt_disable_i,
   input  logic osc_is_rc_i,
   input  logic dly_wr_i,
   input  logic dly_wdata_i,
   input  logic wake_mi_i,
   input  logic cko_pin_i,
   output logic halt_flag_o,
   output logic core_clk_en_o,
   output logic osc_en_o,
   output logic cki_force_hi_o,
   output logic cki_hiz_o,
   output logic wdt_inhibit_o
);
   import hws_pkg::*;

   generate
      if (OSC_DIV < 1) begin : g_bad_div
         $error("halt_wake_seq: OSC_DIV must be at least 1");
      end
   endgenerate

   hs_state_e st_q;
   logic      halt_q;
   logic      dly_q;
   logic      mi_s, cko_s, cko_d;
   logic      cko_rise, wake, need_dly, tmr_load, tmr_done;

   hws_sync #(.STAGES(SYNC_STAGES)) u_sync_mi (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wake_mi_i), .q_o(mi_s));
   hws_sync #(.STAGES(SYNC_STAGES)) u_sync_cko (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cko_pin_i), .q_o(cko_s));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cko_d <= 1'b0;
      else         cko_d <= cko_s;
   end

   assign cko_rise = cko_s && !cko_d;
   assign wake     = mi_s || (osc_is_rc_i && cko_rise);
   assign need_dly = !osc_is_rc_i || dly_q;
   assign tmr_load = (st_q == HS_HALT) && wake && need_dly;

   hws_startup_timer #(.DIV(OSC_DIV), .COUNT(START_COUNT)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .done_o(tmr_done));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dly_q <= 1'b0;
      else if (dly_wr_i) dly_q <= dly_wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= HS_RUN;
         halt_q <= 1'b0;
      end else begin
         unique case (st_q)
            HS_RUN: if (halt_wr_i && halt_wdata_i && !halt_disable_i) begin
               st_q   <= HS_HALT;
               halt_q <= 1'b1;
            end
            HS_HALT: if (wake) begin
               if (need_dly) st_q <= HS_START;
               else begin
                  st_q   <= HS_RUN;
                  halt_q <= 1'b0;
               end
            end
            HS_START: if (tmr_done) begin
               st_q   <= HS_RUN;
               halt_q <= 1'b0;
            end
            default: begin
               st_q   <= HS_RUN;
               halt_q <= 1'b0;
            end
         endcase
      end
   end

   assign halt_flag_o    = halt_q;
   assign core_clk_en_o  = (st_q == HS_RUN);
   assign osc_en_o       = (st_q != HS_HALT);
   assign cki_force_hi_o = (st_q == HS_HALT) && osc_is_rc_i;
   assign cki_hiz_o      = (st_q == HS_HALT) && !osc_is_rc_i;
   assign wdt_inhibit_o  = halt_q;

   p_gate_closed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halt_q |-> !core_clk_en_o);
   p_disable_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == HS_RUN && halt_disable_i) |=> (st_q == HS_RUN));
   p_mi_wakes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == HS_HALT && mi_s) |=> osc_en_o);
   p_xtal_cko_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == HS_HALT && !osc_is_rc_i && !mi_s) |=> (st_q == HS_HALT));
   p_start_waits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == HS_START && !tmr_done) |=> (st_q == HS_START));
   p_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == HS_HALT && wake && !need_dly) |=> core_clk_en_o);
   p_inhibit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !core_clk_en_o |-> wdt_inhibit_o);
   p_cki_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cki_force_hi_o |-> osc_is_rc_i) and (cki_hiz_o |-> !osc_is_rc_i));
endmodule

// File: tb/sim_halt_wake_seq.sv
module sim_halt_wake_seq;
   localparam int CLK_PERIOD = 10;
   localparam int DIV = 10;
   localparam int CNT = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt_wr = 0, halt_wdata = 0, halt_dis = 0, is_rc = 0;
   logic dly_wr = 0, dly_wdata = 0, wake_mi = 0, cko = 0;
   logic halt_flag, core_en, osc_en, force_hi, hiz, wdt_inh;
   int   n_checks = 0;
   int   n_fail = 0;
   bit   finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   halt_wake_seq #(.OSC_DIV(DIV), .START_COUNT(CNT), .SYNC_STAGES(2)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .halt_wr_i(halt_wr), .halt_wdata_i(halt_wdata),
      .halt_disable_i(halt_dis), .osc_is_rc_i(is_rc), .dly_wr_i(dly_wr),
      .dly_wdata_i(dly_wdata), .wake_mi_i(wake_mi), .cko_pin_i(cko),
      .halt_flag_o(halt_flag), .core_clk_en_o(core_en), .osc_en_o(osc_en),
      .cki_force_hi_o(force_hi), .cki_hiz_o(hiz), .wdt_inhibit_o(wdt_inh));

   function automatic int exp_delay(input bit rc, input bit dly);
      return (!rc || dly) ? CNT * DIV : 0;
   endfunction

   function automatic logic [1:0] exp_cki(input bit rc);
      return rc ? 2'b10 : 2'b01;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_halt();
      halt_wr = 1; halt_wdata = 1;
      tick(1);
      halt_wr = 0; halt_wdata = 0;
   endtask

   task automatic write_dly(input bit v);
      dly_wr = 1; dly_wdata = v;
      tick(1);
      dly_wr = 0; dly_wdata = 0;
   endtask

   task automatic fire_wake(input bit use_cko);
      if (use_cko) cko = 1; else wake_mi = 1;
      tick(3);
      cko = 0; wake_mi = 0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      #1;
      check("R10 core_en in reset", 32'(core_en), 1);
      check("R10 halt_flag in reset", 32'(halt_flag), 0);
      tick(2);
      rst_n = 1;
      tick(1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      tick(3);
      rst_n = 1;
      tick(1);
      // R1 reset state
      check("R1 outputs", 32'({core_en, osc_en, halt_flag, wdt_inh, force_hi, hiz}), 32'b110000);

      // R3 halt disabled
      halt_dis = 1;
      write_halt();
      check("R3 halt_flag", 32'(halt_flag), 0);
      check("R3 core_en", 32'(core_en), 1);
      halt_dis = 0;
      tick(2);

      // R2 entry, crystal
      is_rc = 0;
      write_halt();
      check("R2 halt state", 32'({halt_flag, core_en, osc_en}), 32'b100);
      check("R8 inhibit halted", 32'(wdt_inh), 1);
      check("R9 crystal cki", 32'({force_hi, hiz}), 32'(exp_cki(0)));

      // R5 clock-output edge ignored with crystal
      cko = 1;
      tick(6);
      check("R5 xtal cko ignored", 32'(osc_en), 0);
      cko = 0;
      tick(4);
      check("R5 still halted", 32'(halt_flag), 1);

      // R4 + R6 multi-input wake with mandatory delay
      fire_wake(0);
      check("R4 osc on after wake", 32'({osc_en, core_en}), 32'b10);
      check("R9 cki released", 32'({force_hi, hiz}), 0);
      tick(CNT * DIV - 1);
      check("R6 core gated until count", 32'(core_en), 0);
      check("R8 inhibit in startup", 32'(wdt_inh), 1);
      tick(1);
      check("R6 core released", 32'({core_en, halt_flag, wdt_inh}), 32'b100);

      // R7 reset clears delay-enable bit
      is_rc = 1;
      write_dly(1);
      do_reset();
      write_halt();
      check("R9 rc cki", 32'({force_hi, hiz}), 32'(exp_cki(1)));
      fire_wake(1);
      check("R7 bypass after reset", 32'({core_en, halt_flag}), 32'b10);
      tick(3);

      // R10 reset during start-up
      is_rc = 0;
      write_halt();
      fire_wake(0);
      tick(100);
      check("R10 mid startup", 32'(core_en), 0);
      do_reset();
      check("R10 after reset", 32'({core_en, osc_en, halt_flag, wdt_inh}), 32'b1100);

      // random mix
      for (int i = 0; i < 8; i++) begin
         bit rc = 1'($urandom % 2);
         bit dly = 1'($urandom % 2);
         bit use_cko = rc ? 1'($urandom % 2) : 1'b0;
         int d;
         is_rc = rc;
         write_dly(dly);
         tick(3);
         write_halt();
         check("R2 random halt", 32'({halt_flag, core_en}), 32'b10);
         check("R9 random cki", 32'({force_hi, hiz}), 32'(exp_cki(rc)));
         fire_wake(use_cko);
         d = exp_delay(rc, dly);
         if (d == 0) begin
            check("R7 random bypass", 32'(core_en), 1);
         end else begin
            check(use_cko ? "R5 random cko wake" : "R4 random mi wake", 32'({osc_en, core_en}), 32'b10);
            tick(d - 1);
            check("R6 random gated", 32'(core_en), 0);
            tick(1);
            check("R6 random release", 32'({core_en, halt_flag}), 32'b10);
         end
         tick(4);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule